// File: doc/BRIEF.md
# Single-Pin GPIO Controller

This block holds the registers and logic for one general-purpose I/O pin. Software reaches it through a word-addressed register window that spans 0x20 bytes, so many copies can be placed at a fixed pin stride. Each copy drives one pad, with an output value and an output enable. It samples the pad input through a synchronizer and can filter that input against bounces. The filter counts a shared 1 ms tick supplied from outside the block.

The filtered level feeds a trigger detector. The detector can watch for a high or low level, a rising or falling edge, or both edges. A qualifying event sets a pending bit. Software clears that bit by writing 1 to a dedicated clear word. The pending bit leaves the block gated by an interrupt enable. A separate one-cycle event strobe can be enabled to mark each qualifying transition for an external timestamp unit. The register port is plain control: one write strobe and a combinational read. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset, every register reads zero except the float word, which reads 1. `pad_oe`, `irq_pend` and `ts_event` are low.
- R2: Register words are chosen by `bus_addr[4:2]`. Offset 0x00 reads back configuration bits 7:0. Offset 0x04 reads back the 8-bit debounce threshold. Offset 0x0c bit 0 is float. Offset 0x10 bit 0 is the output value. All other bits read zero. Offsets 0x14, 0x18 and 0x1c read zero, and writes to 0x08, 0x18 and 0x1c change nothing.
- R3: `pad_out` equals the output value. `pad_oe` is high only when config bit 0 (enable) is 1, config bit 1 (output) is 1 and float is 0.
- R4: Every write to the configuration word loads float with the inverse of written bit 1. Selecting output therefore unfloats the pad, and selecting input floats it. A later write to 0x0c overrides this.
- R5: Offset 0x08 bit 0 returns the output value while config bit 1 is set. Otherwise it returns the filtered pad level, which follows a pad change after three clock edges when no filter is active.
- R6: With config bit 5 set and a nonzero threshold N, a new pad level is accepted on the N-th tick seen while it differs from the accepted level. A return to the accepted level restarts the count. A threshold of 0, or bit 5 clear, disables filtering.
- R7: Config bits 3:2 select the trigger type (0 none, 1 level, 2 single edge, 3 both edges), and bit 4 is polarity (1 high/rising, 0 low/falling). For types 2 and 3 a qualifying transition sets pending, and polarity is ignored for type 3. Pending is set four edges after the pad change and holds until a write to 0x14 with bit 0 set. A write with bit 0 clear does nothing.
- R8: For type 1, pending follows whether the filtered level equals the polarity, and a clear write has no lasting effect while that level persists.
- R9: With type 0 or config bit 0 clear, pad transitions never set pending.
- R10: `irq_pend` is pending ANDed with config bit 6. Changing bit 6 does not alter the stored pending bit.
- R11: With config bit 7 set, `ts_event` pulses for exactly one cycle, in the same cycle that pending is set, on each qualifying transition. For type 1 this is entry into the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset within the pin window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 1 | Asynchronous pad input |
| pad_out | output | 1 | Pad output value |
| pad_oe | output | 1 | Pad output enable |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| irq_pend | output | 1 | Enabled pending interrupt |
| ts_event | output | 1 | Timestamp event strobe |

## Verification
Latency is counted from the rising edge that captures each input change:
- A register write is visible one edge after its strobe.
- The filtered level and the input word follow a pad change after three edges: two synchronizer stages and the filter register.
- Pending, `irq_pend` and `ts_event` follow one edge later, at the fourth edge. `ts_event` drops again at the fifth.
- With filtering active, the level changes on the edge that samples the N-th tick.

The bench drives every input on a falling edge and counts exactly those edges before it samples on a later falling edge. It also checks one edge early where the timing itself is the requirement. A sweep covers every trigger type, both polarities and both starting levels, and predicts pending and the strobe arithmetically.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

  typedef enum logic [1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_LEVEL = 2'd1,
    TRIG_EDGE  = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  // bit 7 .. bit 0 of the configuration word
  typedef struct packed {
    logic  ts_en;
    logic  irq_en;
    logic  dbc_en;
    logic  pol;
    trig_e trig;
    logic  dir_out;
    logic  pin_en;
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);

  // word indices (byte offset / 4)
  localparam int WORD_CFG   = 0;
  localparam int WORD_DBC   = 1;
  localparam int WORD_IN    = 2;
  localparam int WORD_FLOAT = 3;
  localparam int WORD_OUT   = 4;
  localparam int WORD_CLR   = 5;

endpackage

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
  import gpio_pin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lvl,
  output logic [DATA_W-1:0] rdata,
  output pin_cfg_t          cfg,
  output logic [THR_W-1:0]  thr,
  output logic              float_q,
  output logic              out_q,
  output logic              clr
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             unused_bits;

  assign idx         = addr[ADDR_W-1:2];
  assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:CFG_W]};
  assign clr         = wen && (idx == IDX_W'(WORD_CFG + WORD_CLR)) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '0;
      thr     <= '0;
      float_q <= 1'b1;
      out_q   <= 1'b0;
    end else if (wen) begin
      if (idx == IDX_W'(WORD_CFG)) begin
        cfg     <= pin_cfg_t'(wdata[CFG_W-1:0]);
        float_q <= ~wdata[1];
      end
      if (idx == IDX_W'(WORD_DBC))   thr     <= wdata[THR_W-1:0];
      if (idx == IDX_W'(WORD_FLOAT)) float_q <= wdata[0];
      if (idx == IDX_W'(WORD_OUT))   out_q   <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_W'(WORD_CFG):   rdata[CFG_W-1:0] = cfg;
      IDX_W'(WORD_DBC):   rdata[THR_W-1:0] = thr;
      IDX_W'(WORD_IN):    rdata[0] = cfg.dir_out ? out_q : lvl;
      IDX_W'(WORD_FLOAT): rdata[0] = float_q;
      IDX_W'(WORD_OUT):   rdata[0] = out_q;
      default:            rdata = '0;
    endcase
  end

  // R4: a configuration write leaves float at the inverse of the direction bit
  assert_float_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && idx == IDX_W'(WORD_CFG)) |=> (float_q == !$past(wdata[1])));

endmodule

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int THR_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad_in,
  input  logic             tick,
  input  logic             dbc_en,
  input  logic [THR_W-1:0] thr,
  output logic             lvl
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp;
  logic                   filt_on;
  logic [THR_W-1:0]       cnt;
  logic [THR_W:0]         cnt_inc;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pad_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
      end
    end
  endgenerate

  assign samp    = sync_q[SYNC_STAGES-1];
  assign filt_on = dbc_en && (thr != '0);
  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      cnt <= '0;
    end else if (!filt_on) begin
      lvl <= samp;
      cnt <= '0;
    end else if (samp == lvl) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt_inc >= {1'b0, thr}) begin
        lvl <= samp;
        cnt <= '0;
      end else begin
        cnt <= cnt_inc[THR_W-1:0];
      end
    end
  end

  // R6: while filtering, the accepted level only moves on a tick
  assert_filter_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lvl) && $past(filt_on)) |-> $past(tick));

endmodule

// File: rtl/gpio_pin_trig.sv
module gpio_pin_trig
  import gpio_pin_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_cfg_t cfg,
  input  logic     lvl,
  input  logic     clr,
  output logic     pend,
  output logic     ts_event
);

  logic lvl_q;
  logic changed;
  logic active;
  logic hit;

  assign changed = lvl ^ lvl_q;
  assign active  = (lvl == cfg.pol);

  always_comb begin
    hit = 1'b0;
    if (cfg.pin_en && changed) begin
      case (cfg.trig)
        TRIG_LEVEL, TRIG_EDGE: hit = active;
        TRIG_BOTH:             hit = 1'b1;
        default:               hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q    <= 1'b0;
      pend     <= 1'b0;
      ts_event <= 1'b0;
    end else begin
      lvl_q    <= lvl;
      ts_event <= hit && cfg.ts_en;
      if (cfg.pin_en && cfg.trig == TRIG_LEVEL) pend <= active;
      else if (hit)                              pend <= 1'b1;
      else if (clr)                              pend <= 1'b0;
    end
  end

  // R7: an edge-type pending bit holds until cleared
  assert_edge_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr && (cfg.trig == TRIG_EDGE || cfg.trig == TRIG_BOTH)) |=> pend);

  // R8: a level trigger tracks the active level
  assert_level_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pin_en && cfg.trig == TRIG_LEVEL) |=> (pend == $past(lvl == cfg.pol)));

  // R9: disabled pin or no trigger never raises pending
  assert_no_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!cfg.pin_en || cfg.trig == TRIG_NONE) && !pend) |=> !pend);

  // R11: the strobe needs its enable
  assert_ts_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ts_event |-> $past(cfg.ts_en));

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int THR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pad_in,
  output logic              pad_out,
  output logic              pad_oe,
  input  logic              tick_ms,
  output logic              irq_pend,
  output logic              ts_event
);

  pin_cfg_t         cfg;
  logic [THR_W-1:0] thr;
  logic             float_q;
  logic             out_q;
  logic             clr;
  logic             lvl;
  logic             pend;

  gpio_pin_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .THR_W(THR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr),
    .wdata(bus_wdata), .lvl(lvl), .rdata(bus_rdata), .cfg(cfg),
    .thr(thr), .float_q(float_q), .out_q(out_q), .clr(clr)
  );

  gpio_pin_filter #(
    .SYNC_STAGES(SYNC_STAGES), .THR_W(THR_W)
  ) u_filter (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .tick(tick_ms),
    .dbc_en(cfg.dbc_en), .thr(thr), .lvl(lvl)
  );

  gpio_pin_trig u_trig (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .lvl(lvl), .clr(clr),
    .pend(pend), .ts_event(ts_event)
  );

  assign pad_out  = out_q;
  assign pad_oe   = cfg.pin_en && cfg.dir_out && !float_q;
  assign irq_pend = pend && cfg.irq_en;

endmodule

// File: tb/sim_gpio_pin_ctrl.sv
module sim_gpio_pin_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pad_in = 1'b0;
  logic        pad_out;
  logic        pad_oe;
  logic        tick_ms = 1'b0;
  logic        irq_pend;
  logic        ts_event;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_pin_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .tick_ms(tick_ms),
    .irq_pend(irq_pend), .ts_event(ts_event)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); tick_ms = 1'b1;
    @(negedge clk); tick_ms = 1'b0;
  endtask

  // expected qualifying transition: ty = trigger type, po = polarity
  function automatic logic ehit(int ty, int po, logic o, logic n);
    case (ty)
      1, 2:    return (o != n) && (n == po[0]);
      3:       return o != n;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(5'h00, d); chk("R1 cfg", d, 0);
    rd(5'h04, d); chk("R1 thr", d, 0);
    rd(5'h0c, d); chk("R1 float", d, 1);
    rd(5'h10, d); chk("R1 out", d, 0);
    chk("R1 oe/irq/ts", {pad_oe, irq_pend, ts_event}, 0);

    // R2 register map
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, d); chk("R2 thr", d, 32'hFF);
    wr(5'h18, 32'hFFFF_FFFF); rd(5'h18, d); chk("R2 0x18", d, 0);
    rd(5'h14, d); chk("R2 0x14", d, 0);
    wr(5'h00, 32'hFFFF_FF00); rd(5'h00, d); chk("R2 cfg", d, 0);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d); chk("R2 out", d, 1);
    wr(5'h04, 0);

    // R3 / R4 pad drive and float coupling
    wr(5'h00, 32'h3);
    rd(5'h0c, d); chk("R4 out clears float", d, 0);
    chk("R3 oe on", pad_oe, 1);
    chk("R3 pad_out", pad_out, 1);
    wr(5'h0c, 1); chk("R3 oe floated", pad_oe, 0);
    wr(5'h00, 32'h2); chk("R3 oe disabled", pad_oe, 0);
    rd(5'h0c, d); chk("R4 out w/o enable", d, 0);
    wr(5'h00, 32'h1);
    rd(5'h0c, d); chk("R4 input sets float", d, 1);
    chk("R3 oe input", pad_oe, 0);
    wr(5'h10, 0); chk("R3 pad_out low", pad_out, 0);

    // R5 input readback
    pad_in = 1'b0; step(4);
    wr(5'h00, 32'h3); wr(5'h10, 1);
    rd(5'h08, d); chk("R5 out readback 1", d, 1);
    wr(5'h10, 0); rd(5'h08, d); chk("R5 out readback 0", d, 0);
    wr(5'h00, 32'h1);
    pad_in = 1'b1; step(3); rd(5'h08, d); chk("R5 pad high", d, 1);
    pad_in = 1'b0; step(2); rd(5'h08, d); chk("R5 not yet", d, 1);
    step(1); rd(5'h08, d); chk("R5 three edges", d, 0);

    // R6 debounce
    wr(5'h00, 32'h21);
    pad_in = 1'b1; step(3); rd(5'h08, d); chk("R6 thr0 unfiltered", d, 1);
    pad_in = 1'b0; step(3); rd(5'h08, d); chk("R6 thr0 back", d, 0);
    wr(5'h04, 3);
    pad_in = 1'b1; step(3); rd(5'h08, d); chk("R6 held", d, 0);
    tick(); tick(); rd(5'h08, d); chk("R6 two ticks", d, 0);
    tick(); rd(5'h08, d); chk("R6 third tick", d, 1);
    pad_in = 1'b0; step(3); tick(); tick();
    pad_in = 1'b1; step(3);
    pad_in = 1'b0; step(3); tick(); tick();
    rd(5'h08, d); chk("R6 glitch restart", d, 1);
    tick(); rd(5'h08, d); chk("R6 restart accept", d, 0);
    wr(5'h00, 32'h01);
    pad_in = 1'b1; step(3); rd(5'h08, d); chk("R6 disabled", d, 1);
    wr(5'h04, 0);

    // R7 R8 R9 R11 sweep: type x polarity x starting level
    for (int ty = 0; ty < 4; ty++) begin
      for (int po = 0; po < 2; po++) begin
        for (int ini = 0; ini < 2; ini++) begin
          string tg;
          logic  o, n, h1, h2, ex;
          tg = (ty == 1) ? "R8" : (ty == 0) ? "R9" : "R7";
          o = ini[0]; n = ~ini[0];
          h1 = ehit(ty, po, o, n);
          h2 = ehit(ty, po, n, o);
          pad_in = o;
          wr(5'h00, 32'h1 | (ty << 2) | (po << 4) | 32'hC0);
          step(5);
          wr(5'h14, 1); step(1);
          ex = (ty == 1) && (o == po[0]);
          chk({tg, " start"}, irq_pend, ex);
          pad_in = n; step(4);
          chk("R11 strobe", ts_event, h1);
          ex = (ty == 1) ? (n == po[0]) : h1;
          chk({tg, " first"}, irq_pend, ex);
          step(1);
          chk("R11 one cycle", ts_event, 0);
          pad_in = o; step(4);
          ex = (ty == 1) ? (o == po[0]) : (h1 | h2);
          chk({tg, " second"}, irq_pend, ex);
          wr(5'h14, 0); step(1);
          chk({tg, " clear bit0=0"}, irq_pend, ex);
          wr(5'h14, 1);
          ex = (ty == 1) && (o == po[0]);
          chk({tg, " cleared"}, irq_pend, ex);
        end
      end
    end

    // R9 pin disabled
    pad_in = 1'b0;
    wr(5'h00, 32'h58); step(5); wr(5'h14, 1);
    pad_in = 1'b1; step(4);
    chk("R9 disabled pin", irq_pend, 0);
    wr(5'h00, 32'h59); chk("R9 after enable", irq_pend, 0);

    // R10 interrupt gate
    pad_in = 1'b0;
    wr(5'h00, 32'h19); step(5); wr(5'h14, 1);
    pad_in = 1'b1; step(4);
    chk("R10 gated", irq_pend, 0);
    wr(5'h00, 32'h59); chk("R10 kept pending", irq_pend, 1);
    wr(5'h14, 1); chk("R10 cleared", irq_pend, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule